// File: doc/BRIEF.md
# Two-Channel Audio/Video Switch Control Receiver

This block is a write-only I2C target that sets the switch settings of a two-channel audio/video router. A bus controller sends one write transfer: the target address, then one control byte for output channel 1, then one for output channel 2. The block accepts only this fixed two-byte payload and has no register pointer. It runs on a fast system clock. SCL and SDA arrive as raw pins and are resynchronized and edge-detected inside the block. The block pulls SDA low through an open-drain enable to acknowledge each byte it accepts.

Each stored control byte is decoded into that channel's settings:

- which of four inputs feeds video and audio;
- the video gain step;
- the audio routing of the left and right outputs;
- two general-purpose output levels.

A strap input chooses between the two possible target addresses. Clock stretching, read transfers and arbitration are not part of the block.

Top module: `avsw_i2c_ctrl`

## Requirements
- R1: After reset both control bytes are zero. Each channel then shows source 00 (tuner), gain 0 (0 dB), both audio routes 0 (mute) and both general-purpose levels 1 (high). `sda_pull` is 0.
- R2: The block acknowledges an address byte of {6'b100100, addr_sel, 1'b0}, sent MSB first. That is 0x90 when `addr_sel` is 0 and 0x92 when `addr_sel` is 1. It also acknowledges the two data bytes that follow. The acknowledge is `sda_pull` held at 1 through the ninth SCL clock of the byte.
- R3: An address byte with a different address, or with bit 0 (read/write) equal to 1, is not acknowledged. The block then gives no acknowledge and changes no register until the next Start.
- R4: The first data byte is stored for channel 1 and the second for channel 2, each received MSB first. Byte bits [1:0] are the source select, driven on `src_sel[2c+1:2c]`, where c is 0 for channel 1 and 1 for channel 2. Codes: 00 tuner, 01 input 2, 10 input 3, 11 input 4. Byte bit 3 drives `gain_6db[c]`, where 1 means the 6 dB step.
- R5: Byte bits 4 and 5 drive the general-purpose levels `gpo_lvl[2c]` and `gpo_lvl[2c+1]` inverted. A bit value of 0 gives level 1 (high) and a bit value of 1 gives level 0 (low).
- R6: Byte bits [7:6] set the audio routing. The route codes on `aud_l_route[2c+1:2c]` and `aud_r_route[2c+1:2c]` are 0 for mute, 1 for the left input and 2 for the right input. The modes are:
  - 00: both outputs route 0 (mute).
  - 01: both outputs route 2 (right input).
  - 10: both outputs route 1 (left input).
  - 11: left output route 1, right output route 2 (normal stereo).
- R7: A data byte takes effect only when its acknowledge is given. If the transfer ends after the first data byte, channel 1 is updated and channel 2 keeps its old value. A byte cut short by a Stop or a Start changes nothing.
- R8: Bytes after the second data byte are not acknowledged and change neither register.
- R9: A Start received at any point, including a repeated Start in the middle of a byte, restarts reception with the address byte.
- R10: `sda_pull` changes only while SCL is low, and it is 0 outside acknowledge bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low reset (power-on clear) |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level (wired bus value) |
| addr_sel | input | 1 | Address strap, becomes address bit 1 of the byte |
| sda_pull | output | 1 | Open-drain enable, 1 pulls SDA low |
| src_sel | output | 4 | Source select per channel, 2 bits each |
| gain_6db | output | 2 | Video gain step per channel |
| aud_l_route | output | 4 | Left output route code per channel |
| aud_r_route | output | 4 | Right output route code per channel |
| gpo_lvl | output | 4 | General-purpose output levels, 2 per channel |

## Verification
The acknowledge and the register update both happen three system clocks after the SCL falling edge that ends bit 8 of a byte: two synchronizer stages plus one state register. The acknowledge is released three clocks after the next SCL falling edge. The bench keeps each SCL phase 20 system clocks long, so these delays always fall inside that phase. It samples the acknowledge in the middle of the ninth SCL high phase and reads the decoded outputs only after the transfer's Stop, when every update is long settled. All stimulus and sampling happen on the falling edge of the system clock.

// File: rtl/avsw_i2c_ctrl.sv
module avsw_i2c_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       addr_sel,
  output logic       sda_pull,
  output logic [3:0] src_sel,
  output logic [1:0] gain_6db,
  output logic [3:0] aud_l_route,
  output logic [3:0] aud_r_route,
  output logic [3:0] gpo_lvl
);
  localparam logic [5:0] ADDR_HI = 6'b100100;

  typedef enum logic [1:0] {S_IDLE, S_RX, S_ACK, S_IGN} st_t;

  logic [1:0] scl_m, sda_m;
  logic       scl_s, sda_s, scl_d, sda_d;
  logic       start_c, stop_c, scl_rise, scl_fall;
  st_t        st;
  logic [2:0] bitcnt;
  logic [1:0] bidx;
  logic       got8;
  logic [7:0] shreg, data1_q, data2_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_m <= 2'b11; sda_m <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_d <= scl_m[1];
      sda_d <= sda_m[1];
    end

  assign scl_s    = scl_m[1];
  assign sda_s    = sda_m[1];
  assign start_c  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; bidx <= '0; got8 <= 1'b0;
      shreg <= '0; data1_q <= '0; data2_q <= '0; sda_pull <= 1'b0;
    end else if (start_c) begin
      st <= S_RX; bitcnt <= '0; bidx <= '0; got8 <= 1'b0; sda_pull <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; got8 <= 1'b0; sda_pull <= 1'b0;
    end else begin
      case (st)
        S_RX:
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_s};
            got8   <= (bitcnt == 3'd7);
            bitcnt <= bitcnt + 3'd1;
          end else if (scl_fall && got8) begin
            got8 <= 1'b0;
            if (bidx == 2'd0) begin
              if (shreg == {ADDR_HI, addr_sel, 1'b0}) begin
                sda_pull <= 1'b1; st <= S_ACK;
              end else st <= S_IGN;
            end else if (bidx == 2'd3) st <= S_IGN;
            else begin
              sda_pull <= 1'b1; st <= S_ACK;
              if (bidx == 2'd1) data1_q <= shreg;
              else              data2_q <= shreg;
            end
          end
        S_ACK:
          if (scl_fall) begin
            sda_pull <= 1'b0; st <= S_RX; bitcnt <= '0; bidx <= bidx + 2'd1;
          end
        default: ;
      endcase
    end

  function automatic logic [3:0] route(input logic [1:0] m);
    case (m)
      2'b00:   route = {2'd0, 2'd0};
      2'b01:   route = {2'd2, 2'd2};
      2'b10:   route = {2'd1, 2'd1};
      default: route = {2'd1, 2'd2};
    endcase
  endfunction

  logic [3:0] r1, r2;
  assign r1          = route(data1_q[7:6]);
  assign r2          = route(data2_q[7:6]);
  assign src_sel     = {data2_q[1:0], data1_q[1:0]};
  assign gain_6db    = {data2_q[3], data1_q[3]};
  assign aud_l_route = {r2[3:2], r1[3:2]};
  assign aud_r_route = {r2[1:0], r1[1:0]};
  assign gpo_lvl     = ~{data2_q[5:4], data1_q[5:4]};

  assert_ack_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);
  assert_commit_with_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({data1_q, data2_q}) |-> sda_pull);
  assert_ignore_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |-> !sda_pull);
  assert_no_extra_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> (bidx != 2'd3));
  assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_c |=> (st == S_RX && bitcnt == 3'd0 && bidx == 2'd0 && !sda_pull));
endmodule

// File: tb/avsw_i2c_ctrl_test.sv
module avsw_i2c_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int H = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, addr_sel = 1'b0;
  logic sda_pull, sda_line;
  logic [3:0] src_sel, aud_l_route, aud_r_route, gpo_lvl;
  logic [1:0] gain_6db;
  int errors = 0, checks = 0;
  logic [7:0] exp1 = 8'h00, exp2 = 8'h00;

  assign sda_line = m_sda & ~sda_pull;
  always #(CLK_PERIOD/2) clk = ~clk;

  avsw_i2c_ctrl uut (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .addr_sel(addr_sel), .sda_pull(sda_pull), .src_sel(src_sel), .gain_6db(gain_6db),
    .aud_l_route(aud_l_route), .aud_r_route(aud_r_route), .gpo_lvl(gpo_lvl));

  task automatic wclk(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [13:0] model(input logic [7:0] b);
    logic [1:0] l, r;
    case (b[7:6])
      2'b00: begin l = 2'd0; r = 2'd0; end
      2'b01: begin l = 2'd2; r = 2'd2; end
      2'b10: begin l = 2'd1; r = 2'd1; end
      default: begin l = 2'd1; r = 2'd2; end
    endcase
    return {b[1:0], b[3], l, r, ~b[5], ~b[4], 5'b0};
  endfunction

  task automatic check_regs(input string req);
    check({req, " ch1"}, {18'b0, src_sel[1:0], gain_6db[0], aud_l_route[1:0],
          aud_r_route[1:0], gpo_lvl[1], gpo_lvl[0], 5'b0}, {18'b0, model(exp1)});
    check({req, " ch2"}, {18'b0, src_sel[3:2], gain_6db[1], aud_l_route[3:2],
          aud_r_route[3:2], gpo_lvl[3], gpo_lvl[2], 5'b0}, {18'b0, model(exp2)});
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; wclk(H); m_scl = 1'b1; wclk(H); m_sda = 1'b0; wclk(H);
    m_scl = 1'b0; wclk(H);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wclk(H); m_scl = 1'b1; wclk(H); m_sda = 1'b1; wclk(H);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      m_sda = b[i]; wclk(H); m_scl = 1'b1; wclk(H); m_scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    m_sda = 1'b1; wclk(H); m_scl = 1'b1; wclk(H/2);
    ack = ~sda_line; wclk(H/2); m_scl = 1'b0;
  endtask

  task automatic transfer(input logic [7:0] a, input logic [7:0] d1,
                          input logic [7:0] d2, output logic [2:0] acks);
    logic k;
    i2c_start;
    send_byte(a, k);  acks[2] = k;
    send_byte(d1, k); acks[1] = k;
    send_byte(d2, k); acks[0] = k;
    i2c_stop;
  endtask

  task automatic t_reset;
    check_regs("R1 reset");
    check("R1 sda_pull idle", {31'b0, sda_pull}, 32'd0);
  endtask

  task automatic t_basic;
    logic [2:0] acks;
    addr_sel = 1'b0;
    transfer(8'h90, 8'hC9, 8'h36, acks);
    exp1 = 8'hC9; exp2 = 8'h36;
    check("R2 acks 0x90", {29'b0, acks}, 32'd7);
    check_regs("R4 R5 R6 write 0x90");
    check("R10 released after stop", {31'b0, sda_pull}, 32'd0);
  endtask

  task automatic t_addr_sel;
    logic [2:0] acks;
    addr_sel = 1'b1;
    transfer(8'h90, 8'h11, 8'h22, acks);
    check("R3 wrong address no ack", {29'b0, acks}, 32'd0);
    check_regs("R3 wrong address ignored");
    transfer(8'h92, 8'h5A, 8'hA7, acks);
    exp1 = 8'h5A; exp2 = 8'hA7;
    check("R2 acks 0x92", {29'b0, acks}, 32'd7);
    check_regs("R4 R6 write 0x92");
  endtask

  task automatic t_read;
    logic [2:0] acks;
    transfer(8'h93, 8'hFF, 8'hFF, acks);
    check("R3 read bit no ack", {29'b0, acks}, 32'd0);
    check_regs("R3 read ignored");
  endtask

  task automatic t_trunc;
    logic k;
    i2c_start; send_byte(8'h92, k); send_byte(8'h81, k); i2c_stop;
    exp1 = 8'h81;
    check("R7 data1 ack", {31'b0, k}, 32'd1);
    check_regs("R7 truncated after data1");
    i2c_start; send_byte(8'h92, k); send_byte(8'h0F, k); send_bits(8'hF0, 4); i2c_stop;
    exp1 = 8'h0F;
    check_regs("R7 stop inside data2");
  endtask

  task automatic t_extra;
    logic k;
    i2c_start; send_byte(8'h92, k); send_byte(8'h44, k); send_byte(8'h88, k);
    send_byte(8'hFF, k);
    check("R8 extra byte no ack", {31'b0, k}, 32'd0);
    send_byte(8'h00, k);
    check("R8 second extra no ack", {31'b0, k}, 32'd0);
    i2c_stop;
    exp1 = 8'h44; exp2 = 8'h88;
    check_regs("R8 extra bytes discarded");
  endtask

  task automatic t_rstart;
    logic [2:0] acks;
    logic k;
    i2c_start; send_byte(8'h92, k); send_bits(8'hFF, 3);
    transfer(8'h92, 8'h33, 8'hCC, acks);
    exp1 = 8'h33; exp2 = 8'hCC;
    check("R9 acks after repeated start", {29'b0, acks}, 32'd7);
    check_regs("R9 repeated start mid-byte");
    i2c_start; send_byte(8'h92, k); send_byte(8'h3C, k);
    transfer(8'h92, 8'h96, 8'h69, acks);
    exp1 = 8'h96; exp2 = 8'h69;
    check_regs("R9 repeated start after data1");
    check("R10 idle after all", {31'b0, sda_pull}, 32'd0);
  endtask

  initial begin
    wclk(5); rst_n = 1'b1; wclk(5);
    t_reset; t_basic; t_addr_sel; t_read; t_trunc; t_extra; t_rstart;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule